// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave

This block is a two-wire serial slave that holds the control bytes of a clock generator. A host reaches one register per transfer. To write, it sends the device address, a command byte and one data byte. To read, it sends the device address and a command byte, then a repeated START, the address with the read bit set, and takes back one byte. The command byte must have its top bit set to select a byte operation, and its lower seven bits give the register offset.

Three registers are implemented. The first holds the frequency-select field, which software may change only while an unlock bit in the same register is set. While that bit is clear, the field reads back the live hardware strap levels. The second register holds the spread-spectrum and CPU-pair controls. The third holds the PCI clock controls. Strap inputs are mirrored into read-only bits. The block presents every register value on its ports, along with the frequency selection currently in effect.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: A write transfer (START, address with bit0=0, command, one data byte, STOP) is ACKed on the address, command and data bytes, and it updates the addressed register.
- R2: A read transfer (START, address with write, command, repeated START, address with bit0=1) is ACKed, and the slave then drives the addressed register MSB first. It releases SDA after the eighth bit.
- R3: A command byte with bit7=1 sets the offset from bits 6:0 and is ACKed. A command byte with bit7=0 is NACKed, and the following bytes are neither ACKed nor written.
- R4: An address byte whose upper seven bits differ from DEV_ADDR gets no ACK, and SDA is never pulled low before the next START.
- R5: In offset 0, bit3 is the unlock bit and is always writable. Bits 6:4 and bit1 take write data only if the unlock bit was already 1 before that write. While the unlock bit is 0, bits 6,5,4,1 read back strap_fs[2], strap_fs[1], strap_fs[0] and strap_fs[3].
- R6: Offset 0 bit0 reads strap_mode, and bits 7 and 2 always read 0.
- R7: Offset 1 resets to bits 7:1 = 0111110, and bit0 reads strap_mult0. Bits 7:1 are writable.
- R8: Offset 2 resets to 0x40. Bits 7:6 are writable, and bits 5:0 always read 0.
- R9: Offsets 3 to 127 read 0x00. Writes to them are ACKed and change nothing.
- R10: A START in any state restarts address reception, and a STOP returns the slave to idle. A transfer cut off before its data byte completes writes nothing.
- R11: fs_sel gives the frequency selection in effect, {FS3,FS2,FS1,FS0}: the stored field while unlocked, otherwise strap_fs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_fs | input | 4 | Frequency-select strap levels {FS3..FS0} |
| strap_mode | input | 1 | CPU-interface-mode strap |
| strap_mult0 | input | 1 | Current-multiplier strap |
| cfg_fsel | output | 8 | Read value of offset 0 |
| cfg_cpu | output | 8 | Read value of offset 1 |
| cfg_pci | output | 8 | Read value of offset 2 |
| fs_sel | output | 4 | Frequency selection in effect |

## Verification
The assertions check four things on every cycle: a detected START forces address reception, a STOP forces idle, SDA is never driven while idle or ignoring, and the reserved bits stay zero with fs_sel consistent with the offset-0 view. The remaining behaviour only shows up in bench scenarios. This covers ACK and NACK patterns on the wire, the write gating that depends on the unlock bit's earlier value, strap tracking, unimplemented offsets, and aborted transfers. The bench also compares register contents with a model after random write and read sequences.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  parameter int REG_W = 8;
  parameter int OFF_W = 7;
  parameter int FS_W  = 4;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CMD  = 3'd2,
    PH_WDAT = 3'd3,
    PH_RDAT = 3'd4,
    PH_ACK  = 3'd5,
    PH_IGN  = 3'd6
  } phase_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [REG_W-1:0] rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [OFF_W-1:0] ptr,
  output logic [REG_W-1:0] wr_data,
  output phase_t           phase
);
  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W);

  phase_t           st, nxt;
  logic [CNT_W-1:0] bitcnt;
  logic [REG_W-1:0] shreg, tx;
  logic             ack_c;
  phase_t           nxt_c;

  // decision taken when a received byte completes
  always_comb begin
    ack_c = 1'b0;
    nxt_c = PH_IGN;
    case (st)
      PH_ADDR: if (shreg[7:1] == DEV_ADDR) begin
        ack_c = 1'b1;
        nxt_c = shreg[0] ? PH_RDAT : PH_CMD;
      end
      PH_CMD: if (shreg[7]) begin
        ack_c = 1'b1;
        nxt_c = PH_WDAT;
      end
      PH_WDAT: ack_c = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      st     <= PH_IDLE;
      nxt    <= PH_IGN;
      sda_oe <= 1'b0;
      bitcnt <= '0;
      ptr    <= '0;
      shreg  <= '0;
      tx     <= '0;
    end else if (start_det) begin
      st     <= PH_ADDR;
      sda_oe <= 1'b0;
      bitcnt <= '0;
    end else if (stop_det) begin
      st     <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        PH_ADDR, PH_CMD, PH_WDAT: begin
          if (scl_rise && bitcnt < LAST) begin
            shreg  <= {shreg[REG_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == LAST) begin
            st     <= PH_ACK;
            nxt    <= nxt_c;
            sda_oe <= ack_c;
            bitcnt <= '0;
            if (st == PH_CMD && shreg[7]) ptr <= shreg[OFF_W-1:0];
            if (st == PH_WDAT) wr_en <= 1'b1;
          end
        end
        PH_ACK: if (scl_fall) begin
          st <= nxt;
          if (nxt == PH_RDAT) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[REG_W-1];
          end else begin
            sda_oe <= 1'b0;
          end
        end
        PH_RDAT: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          else if (scl_fall) begin
            if (bitcnt == LAST) begin
              sda_oe <= 1'b0;
              st     <= PH_IGN;
            end else begin
              tx     <= {tx[REG_W-2:0], 1'b0};
              sda_oe <= ~tx[REG_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_data = shreg;
  assign phase   = st;
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [REG_W-1:0] wr_data,
  input  logic [FS_W-1:0]  strap_fs,
  input  logic             strap_mode,
  input  logic             strap_mult0,
  output logic [REG_W-1:0] view0,
  output logic [REG_W-1:0] view1,
  output logic [REG_W-1:0] view2,
  output logic [REG_W-1:0] rd_data,
  output logic [FS_W-1:0]  fs_sel
);
  logic            unlock;
  logic [FS_W-1:0] fs_sw, fs_eff, fs_q;
  logic [6:0]      cpu_hi;
  logic [1:0]      pci_hi;
  logic            mode_q, mult_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock <= 1'b0;
      fs_sw  <= '0;
      cpu_hi <= 7'b0111110;
      pci_hi <= 2'b01;
    end else if (wr_en) begin
      case (off)
        7'd0: begin
          unlock <= wr_data[3];
          if (unlock) fs_sw <= {wr_data[1], wr_data[6], wr_data[5], wr_data[4]};
        end
        7'd1: cpu_hi <= wr_data[7:1];
        7'd2: pci_hi <= wr_data[7:6];
        default: ;
      endcase
    end
  end

  assign fs_eff = unlock ? fs_sw : fs_q;

  always_ff @(posedge clk) begin
    fs_q   <= strap_fs;
    mode_q <= strap_mode;
    mult_q <= strap_mult0;
    view0  <= {1'b0, fs_eff[2], fs_eff[1], fs_eff[0], unlock, 1'b0, fs_eff[3], mode_q};
    view1  <= {cpu_hi, mult_q};
    view2  <= {pci_hi, 6'b0};
    fs_sel <= fs_eff;
  end

  always_comb begin
    case (off)
      7'd0:    rd_data = view0;
      7'd1:    rd_data = view1;
      7'd2:    rd_data = view2;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [FS_W-1:0]  strap_fs,
  input  logic             strap_mode,
  input  logic             strap_mult0,
  output logic [REG_W-1:0] cfg_fsel,
  output logic [REG_W-1:0] cfg_cpu,
  output logic [REG_W-1:0] cfg_pci,
  output logic [FS_W-1:0]  fs_sel
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det, wr_en;
  logic [OFF_W-1:0] ptr;
  logic [REG_W-1:0] wr_data, rd_data;
  phase_t           phase;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .ptr(ptr),
    .wr_data(wr_data), .phase(phase)
  );

  clkcfg_regbank u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .off(ptr), .wr_data(wr_data),
    .strap_fs(strap_fs), .strap_mode(strap_mode), .strap_mult0(strap_mult0),
    .view0(cfg_fsel), .view1(cfg_cpu), .view2(cfg_pci),
    .rd_data(rd_data), .fs_sel(fs_sel)
  );
endmodule

// File: rtl/clkcfg_smb_chk.sv
module clkcfg_smb_chk
  import clkcfg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start_det,
  input logic             stop_det,
  input logic [2:0]       phase,
  input logic             sda_oe,
  input logic [REG_W-1:0] cfg_fsel,
  input logic [REG_W-1:0] cfg_pci,
  input logic [FS_W-1:0]  fs_sel
);
  // R10
  start_rst_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> phase == PH_ADDR);
  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> phase == PH_IDLE);
  // R4
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE || phase == PH_IGN) |-> !sda_oe);
  // R6
  fsel_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_fsel[7] == 1'b0 && cfg_fsel[2] == 1'b0);
  // R8
  pci_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_pci[5:0] == 6'b0);
  // R11
  fs_view_chk: assert property (@(posedge clk) disable iff (rst)
    fs_sel == {cfg_fsel[1], cfg_fsel[6], cfg_fsel[5], cfg_fsel[4]});
endmodule

bind clkcfg_smb_slave clkcfg_smb_chk u_chk (
  .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
  .phase(phase), .sda_oe(sda_oe), .cfg_fsel(cfg_fsel), .cfg_pci(cfg_pci),
  .fs_sel(fs_sel)
);

// File: tb/clkcfg_smb_slave_bench.sv
module clkcfg_smb_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WATCHDOG = 190000;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, strap_mode, strap_mult0;
  logic [3:0] strap_fs, fs_sel;
  logic [7:0] cfg_fsel, cfg_cpu, cfg_pci;
  wire  sda_line = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  bit done = 0, oe_seen = 0;

  // bench model
  bit       m_unlock;
  bit [3:0] m_fs;
  bit [6:0] m_cpu;
  bit [1:0] m_pci;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkcfg_smb_slave u_clkcfg_smb_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_fs(strap_fs), .strap_mode(strap_mode), .strap_mult0(strap_mult0),
    .cfg_fsel(cfg_fsel), .cfg_cpu(cfg_cpu), .cfg_pci(cfg_pci), .fs_sel(fs_sel)
  );

  always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

  function automatic bit [3:0] fs_eff();
    return m_unlock ? m_fs : strap_fs;
  endfunction

  function automatic bit [7:0] exp_view(input int off);
    bit [3:0] f = fs_eff();
    case (off)
      0: return {1'b0, f[2], f[1], f[0], m_unlock, 1'b0, f[3], strap_mode};
      1: return {m_cpu, strap_mult0};
      2: return {m_pci, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input int off, input bit [7:0] d);
    case (off)
      0: begin
        if (m_unlock) m_fs = {d[1], d[6], d[5], d[4]};
        m_unlock = d[3];
      end
      1: m_cpu = d[7:1];
      2: m_pci = d[7:6];
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_out(input bit b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input bit [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(s);
    ack = ~s;
  endtask

  task automatic recv_byte(output bit [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_in(s);
      d[i] = s;
    end
    bit_out(1'b1); // master NACK
  endtask

  task automatic do_write(input bit [6:0] a, input bit [7:0] cmd, input bit [7:0] d,
                          output bit [2:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
    wq(4);
  endtask

  task automatic do_read(input bit [7:0] cmd, output bit [7:0] d, output bit [2:0] acks);
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    bus_start();
    send_byte({ADDR, 1'b1}, acks[0]);
    recv_byte(d);
    bus_stop();
    wq(4);
  endtask

  task automatic check_views(input string tag);
    chk({tag, " view0"}, cfg_fsel, exp_view(0));
    chk({tag, " view1"}, cfg_cpu, exp_view(1));
    chk({tag, " view2"}, cfg_pci, exp_view(2));
    chk({tag, " fs_sel"}, fs_sel, fs_eff());
  endtask

  initial begin
    wq(WATCHDOG);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [2:0] acks;
    bit [7:0] rd;
    bit       b;
    int       seed;
    seed = $urandom(32'hC10C);
    strap_fs = 4'b1010; strap_mode = 1'b1; strap_mult0 = 1'b0;
    m_unlock = 0; m_fs = 0; m_cpu = 7'b0111110; m_pci = 2'b01;
    wq(5); rst = 1'b0; wq(5);

    // R6 R7 R8 R11 reset state
    check_views("R7 reset");

    // R1 R7 write and read back offset 1
    do_write(ADDR, 8'h81, 8'hA5, acks); model_wr(1, 8'hA5);
    chk("R1 write acks", acks, 3'b111);
    do_read(8'h81, rd, acks);
    chk("R2 read acks", acks, 3'b111);
    chk("R2 read offset1", rd, exp_view(1));
    chk("R7 cpu view", cfg_cpu, exp_view(1));
    chk("R2 sda released", sda_oe, 0);

    // R8 offset 2 reserved bits
    do_write(ADDR, 8'h82, 8'hFF, acks); model_wr(2, 8'hFF);
    do_read(8'h82, rd, acks);
    chk("R8 read offset2", rd, 8'hC0);

    // R5 locked field ignores writes
    do_write(ADDR, 8'h80, 8'h72, acks); model_wr(0, 8'h72);
    chk("R5 locked view0", cfg_fsel, exp_view(0));
    do_write(ADDR, 8'h80, 8'h08, acks); model_wr(0, 8'h08);
    chk("R5 unlock same write", fs_sel, 4'h0);
    do_write(ADDR, 8'h80, 8'h7A, acks); model_wr(0, 8'h7A);
    chk("R11 fs_sel unlocked", fs_sel, 4'hF);
    do_read(8'h80, rd, acks);
    chk("R5 read offset0", rd, exp_view(0));
    strap_fs = 4'b0101; wq(6);
    chk("R5 straps ignored while unlocked", cfg_fsel, exp_view(0));
    do_write(ADDR, 8'h80, 8'h00, acks); model_wr(0, 8'h00);
    chk("R5 relock tracks straps", cfg_fsel, exp_view(0));
    strap_fs = 4'b1100; strap_mode = 1'b0; wq(6);
    chk("R6 strap follow", cfg_fsel, exp_view(0));
    chk("R11 fs_sel straps", fs_sel, 4'b1100);

    // R9 unimplemented offsets
    do_read(8'h85, rd, acks);
    chk("R9 read acks", acks, 3'b111);
    chk("R9 read value", rd, 8'h00);
    do_write(ADDR, 8'hFF, 8'h55, acks);
    chk("R9 write acks", acks, 3'b111);
    check_views("R9 no effect");

    // R3 command bit7 clear
    do_write(ADDR, 8'h01, 8'h00, acks);
    chk("R3 nack pattern", acks, 3'b100);
    check_views("R3 no write");

    // R4 wrong address
    oe_seen = 0;
    do_write(7'h2C, 8'h81, 8'h00, acks);
    chk("R4 no ack", acks, 3'b000);
    chk("R4 sda never driven", oe_seen, 0);
    check_views("R4 no write");

    // R10 START mid address, then full write
    bus_start();
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    do_write(ADDR, 8'h82, 8'h40, acks); model_wr(2, 8'h40);
    chk("R10 restart acks", acks, 3'b111);
    chk("R10 restart write", cfg_pci, exp_view(2));
    // R10 STOP inside data byte
    bus_start();
    send_byte({ADDR, 1'b0}, b);
    send_byte(8'h81, b);
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    bus_stop(); wq(4);
    chk("R10 aborted write", cfg_cpu, exp_view(1));

    // random mix, R1 R2 R5
    for (int n = 0; n < 30; n++) begin
      int off;
      bit [7:0] d;
      off = $urandom % 4;
      d = 8'($urandom);
      if ($urandom % 4 == 0) begin
        strap_fs = 4'($urandom); strap_mult0 = 1'($urandom); strap_mode = 1'($urandom);
        wq(6);
      end
      do_write(ADDR, {1'b1, 7'(off)}, d, acks); model_wr(off, d);
      chk("R1 random acks", acks, 3'b111);
      do_read({1'b1, 7'(off)}, rd, acks);
      chk("R2 random read", rd, exp_view(off));
      chk("R11 random fs_sel", fs_sel, fs_eff());
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule